// File: doc/BRIEF.md
# Audio Clock Ratio Detector and Power Sequencer

This block watches a master audio clock and a frame (left/right) clock. All of its logic runs on a faster, free-running reference clock. It counts master-clock cycles over each frame period and maps the count onto one of ten legal ratios. It also measures the frame period in reference cycles, which gives an estimate of the sample rate. From the ratio and the rate it picks a speed class: single, double or quad.

Once a legal ratio is found, the block brings up the downstream converter path in order. The voltage reference comes up first. The converters follow a few frames later. Audio stays forced to zero until a fixed number of frame periods has passed since the ratio was accepted. If the ratio class or the speed class changes while running, the block drops back into detection and the settle interval starts again. If either input clock goes quiet for a timeout, the block returns to its power-down state.

Top module: `clk_ratio_seq`

## Requirements
- R1: During and after reset, and while in power-down, `ref_en`, `conv_en` and `audio_en` are 0, `force_zero` is 1, `ratio_code` is 4'hF and `speed_mode` is 2'b11.
- R2: An input clock is absent once no edge of it has been seen for `ABSENT_CYC` reference cycles. Whenever either clock is absent, the block is in power-down (R1 outputs).
- R3: The ratio is the number of master-clock rising edges between consecutive frame-clock rising edges. `ratio_code` values 0 to 9 stand for the ratios 64, 96, 128, 192, 256, 384, 512, 768, 1024 and 1152, in that order.
- R4: A count within ±`RATIO_TOL` (default 2) of a legal ratio maps to that ratio. Any other count is rejected. A rejected count keeps the block in detection with `ratio_code` 4'hF, all enables low and audio muted.
- R5: The `speed_mode` encoding is 0 single, 1 double, 2 quad and 3 none. Ratios 64 and 96 always select quad. Ratios 512 and above always select single.
- R6: For ratios 128 and 192, the block selects quad when the frame period is shorter than `REF_HZ/SPLIT_QD_HZ` reference cycles, and double otherwise.
- R7: For ratios 256 and 384, the block selects double when the frame period is shorter than `REF_HZ/SPLIT_DS_HZ` reference cycles, and single otherwise.
- R8: Detection needs one complete frame after the clocks appear. When a legal ratio is accepted, `ref_en` rises at once. `conv_en` rises `REF_FRAMES` frame periods later. `conv_en` is never high without `ref_en`.
- R9: `audio_en` rises, and `force_zero` falls, `SETTLE_FRAMES` frame periods after acceptance. Until then `force_zero` stays high.
- R10: While powered up, a frame whose ratio code or speed class differs from the accepted one sends the block back to detection. That frame drops all enables and forces zero. The next legal frame is accepted, and the full sequence from R8 and R9 restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_clk_in | input | 1 | Master audio clock, sampled by the reference clock |
| frame_clk_in | input | 1 | Frame (left/right) clock, sampled by the reference clock |
| ratio_code | output | 4 | Accepted ratio index 0..9, or 4'hF when none |
| speed_mode | output | 2 | Speed class: 0 single, 1 double, 2 quad, 3 none |
| ref_en | output | 1 | Voltage-reference enable |
| conv_en | output | 1 | Converter enable |
| force_zero | output | 1 | Forces zero data downstream |
| audio_en | output | 1 | Audio output released |

## Verification
The checks assume that both input clocks are slow enough for the reference clock to see every level: each high and low phase lasts at least one reference cycle. They also assume that frame-clock edges line up with master-clock edges. The stimulus drives both clocks from the falling edge of the reference clock, with master-clock half periods of whole reference cycles. Every frame holds an exact, even number of master-clock periods. Ratio changes happen only at frame boundaries. Frame periods stay well inside the absence timeout, so that a timeout occurs only when the stimulus deliberately stops both clocks.

// File: rtl/crs_pkg.sv
package crs_pkg;

   localparam int         NUM_RATIOS = 10;
   localparam logic [3:0] CODE_NONE  = 4'hF;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2,
      SPD_NONE   = 2'd3
   } speed_t;

   typedef enum logic [2:0] {
      PS_OFF,
      PS_DETECT,
      PS_REFUP,
      PS_SETTLE,
      PS_RUN
   } pstate_t;

   // legal master-to-frame ratios, ascending; the index is the output code
   function automatic int ratio_of(input int idx);
      case (idx)
         0:       return 64;
         1:       return 96;
         2:       return 128;
         3:       return 192;
         4:       return 256;
         5:       return 384;
         6:       return 512;
         7:       return 768;
         8:       return 1024;
         default: return 1152;
      endcase
   endfunction

endpackage

// File: rtl/crs_edge_watch.sv
module crs_edge_watch #(
   parameter int SYNC_STAGES = 2,
   parameter int ABSENT_CYC  = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise,
   output logic alive
);
   localparam int TW = $clog2(ABSENT_CYC + 1);

   logic [SYNC_STAGES-1:0] chain;
   logic                   last;
   logic                   synced;
   logic                   toggle;
   logic [TW-1:0]          timer;

   // synchronizer depth picks the variant
   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= sig_in;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], sig_in};
      end
   end

   assign synced = chain[SYNC_STAGES-1];
   assign toggle = synced ^ last;
   assign rise   = synced & ~last;
   assign alive  = (timer != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last  <= 1'b0;
         timer <= '0;
      end else begin
         last <= synced;
         if (toggle)
            timer <= TW'(ABSENT_CYC);
         else if (timer != '0)
            timer <= timer - 1'b1;
      end
   end

endmodule

// File: rtl/crs_frame_meter.sv
module crs_frame_meter #(
   parameter int CW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          present,
   input  logic          mck_rise,
   input  logic          frm_rise,
   output logic          done,
   output logic [CW-1:0] mck_cnt,
   output logic [CW-1:0] ref_cnt
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic          armed;
   logic [CW-1:0] mck_acc;
   logic [CW-1:0] ref_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         done    <= 1'b0;
         mck_acc <= '0;
         ref_acc <= '0;
         mck_cnt <= '0;
         ref_cnt <= '0;
      end else begin
         done <= 1'b0;
         if (frm_rise) begin
            // close the frame; this cycle opens the next one
            done    <= armed;
            mck_cnt <= mck_acc;
            ref_cnt <= ref_acc;
            mck_acc <= mck_rise ? CW'(1) : '0;
            ref_acc <= CW'(1);
            armed   <= 1'b1;
         end else begin
            if (!present) armed <= 1'b0;
            if (mck_rise && mck_acc != CNT_MAX) mck_acc <= mck_acc + 1'b1;
            if (ref_acc != CNT_MAX)             ref_acc <= ref_acc + 1'b1;
         end
      end
   end

endmodule

// File: rtl/crs_ratio_classify.sv
module crs_ratio_classify
   import crs_pkg::*;
#(
   parameter int CW     = 17,
   parameter int TOL    = 2,
   parameter int QD_LIM = 746,
   parameter int DS_LIM = 1492
) (
   input  logic [CW-1:0] mck_cnt,
   input  logic [CW-1:0] ref_cnt,
   output logic [3:0]    code,
   output speed_t        speed
);
   localparam logic [CW-1:0] QD_CYC = CW'(QD_LIM);
   localparam logic [CW-1:0] DS_CYC = CW'(DS_LIM);

   logic [NUM_RATIOS-1:0] hit;

   for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
      localparam logic [CW-1:0] LO = CW'(ratio_of(i) - TOL);
      localparam logic [CW-1:0] HI = CW'(ratio_of(i) + TOL);
      assign hit[i] = (mck_cnt >= LO) && (mck_cnt <= HI);
   end

   always_comb begin
      code = CODE_NONE;
      for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
         if (hit[i]) code = 4'(i);
      end
   end

   always_comb begin
      case (code)
         4'd0, 4'd1: speed = SPD_QUAD;
         4'd2, 4'd3: speed = (ref_cnt < QD_CYC) ? SPD_QUAD : SPD_DOUBLE;
         4'd4, 4'd5: speed = (ref_cnt < DS_CYC) ? SPD_DOUBLE : SPD_SINGLE;
         4'd6, 4'd7,
         4'd8, 4'd9: speed = SPD_SINGLE;
         default:    speed = SPD_NONE;
      endcase
   end

endmodule

// File: rtl/crs_power_seq.sv
module crs_power_seq
   import crs_pkg::*;
#(
   parameter int REF_FRAMES    = 2,
   parameter int SETTLE_FRAMES = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       present,
   input  logic       frame_done,
   input  logic [3:0] code_in,
   input  speed_t     speed_in,
   output logic [3:0] ratio_code,
   output logic [1:0] speed_mode,
   output logic       ref_en,
   output logic       conv_en,
   output logic       force_zero,
   output logic       audio_en
);
   localparam int            FW    = $clog2(SETTLE_FRAMES + 1);
   localparam logic [FW-1:0] REF_N = FW'(REF_FRAMES);
   localparam logic [FW-1:0] SET_N = FW'(SETTLE_FRAMES);

   pstate_t       state;
   logic [FW-1:0] cnt;
   logic [FW-1:0] cnt_nx;
   logic [3:0]    code_q;
   speed_t        speed_q;
   logic          changed;

   assign cnt_nx  = cnt + 1'b1;
   assign changed = (code_in != code_q) || (speed_in != speed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PS_OFF;
         cnt     <= '0;
         code_q  <= CODE_NONE;
         speed_q <= SPD_NONE;
      end else if (!present) begin
         state   <= PS_OFF;
         code_q  <= CODE_NONE;
         speed_q <= SPD_NONE;
      end else begin
         case (state)
            PS_OFF: state <= PS_DETECT;
            PS_DETECT: begin
               if (frame_done && code_in != CODE_NONE) begin
                  code_q  <= code_in;
                  speed_q <= speed_in;
                  cnt     <= '0;
                  state   <= PS_REFUP;
               end
            end
            default: begin
               if (frame_done) begin
                  if (changed) begin
                     state   <= PS_DETECT;
                     code_q  <= CODE_NONE;
                     speed_q <= SPD_NONE;
                  end else begin
                     if (cnt != SET_N) cnt <= cnt_nx;
                     if (state == PS_REFUP && cnt_nx == REF_N) state <= PS_SETTLE;
                     if (state != PS_RUN && cnt_nx == SET_N)   state <= PS_RUN;
                  end
               end
            end
         endcase
      end
   end

   assign ratio_code = code_q;
   assign speed_mode = speed_q;
   assign ref_en     = (state == PS_REFUP) || (state == PS_SETTLE) || (state == PS_RUN);
   assign conv_en    = (state == PS_SETTLE) || (state == PS_RUN);
   assign audio_en   = (state == PS_RUN);
   assign force_zero = (state != PS_RUN);

endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
   import crs_pkg::*;
#(
   parameter int REF_HZ        = 100_000_000,
   parameter int SPLIT_QD_HZ   = 134_000,
   parameter int SPLIT_DS_HZ   = 67_000,
   parameter int ABSENT_CYC    = 40_000,
   parameter int SYNC_STAGES   = 2,
   parameter int RATIO_TOL     = 2,
   parameter int REF_FRAMES    = 2,
   parameter int SETTLE_FRAMES = 2000
) (
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       mst_clk_in,
   input  logic       frame_clk_in,
   output logic [3:0] ratio_code,
   output logic [1:0] speed_mode,
   output logic       ref_en,
   output logic       conv_en,
   output logic       force_zero,
   output logic       audio_en
);
   localparam int CW     = $clog2(2 * ABSENT_CYC + 2);
   localparam int QD_LIM = REF_HZ / SPLIT_QD_HZ;
   localparam int DS_LIM = REF_HZ / SPLIT_DS_HZ;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (RATIO_TOL < 0 || RATIO_TOL > 15) begin : g_bad_tol
      $error("RATIO_TOL must lie in 0..15 so windows stay disjoint");
   end
   if (REF_FRAMES < 1 || REF_FRAMES >= SETTLE_FRAMES) begin : g_bad_seq
      $error("REF_FRAMES must be at least 1 and below SETTLE_FRAMES");
   end
   if (DS_LIM <= QD_LIM) begin : g_bad_split
      $error("SPLIT_DS_HZ must be below SPLIT_QD_HZ");
   end
   if (DS_LIM >= (1 << CW) || 1154 + RATIO_TOL >= (1 << CW)) begin : g_bad_width
      $error("ABSENT_CYC too small for the ratio and rate limits");
   end

   logic          mck_rise, mck_alive;
   logic          frm_rise, frm_alive;
   logic          present;
   logic          frame_done;
   logic [CW-1:0] mck_cnt, ref_cnt;
   logic [3:0]    code_w;
   speed_t        speed_w;

   crs_edge_watch #(.SYNC_STAGES(SYNC_STAGES), .ABSENT_CYC(ABSENT_CYC)) mck_watch_i (
      .clk(clk_ref), .rst_n(rst_n), .sig_in(mst_clk_in),
      .rise(mck_rise), .alive(mck_alive)
   );

   crs_edge_watch #(.SYNC_STAGES(SYNC_STAGES), .ABSENT_CYC(ABSENT_CYC)) frm_watch_i (
      .clk(clk_ref), .rst_n(rst_n), .sig_in(frame_clk_in),
      .rise(frm_rise), .alive(frm_alive)
   );

   assign present = mck_alive & frm_alive;

   crs_frame_meter #(.CW(CW)) meter_i (
      .clk(clk_ref), .rst_n(rst_n), .present(present),
      .mck_rise(mck_rise), .frm_rise(frm_rise),
      .done(frame_done), .mck_cnt(mck_cnt), .ref_cnt(ref_cnt)
   );

   crs_ratio_classify #(.CW(CW), .TOL(RATIO_TOL), .QD_LIM(QD_LIM), .DS_LIM(DS_LIM)) classify_i (
      .mck_cnt(mck_cnt), .ref_cnt(ref_cnt), .code(code_w), .speed(speed_w)
   );

   crs_power_seq #(.REF_FRAMES(REF_FRAMES), .SETTLE_FRAMES(SETTLE_FRAMES)) seq_i (
      .clk(clk_ref), .rst_n(rst_n), .present(present), .frame_done(frame_done),
      .code_in(code_w), .speed_in(speed_w),
      .ratio_code(ratio_code), .speed_mode(speed_mode),
      .ref_en(ref_en), .conv_en(conv_en),
      .force_zero(force_zero), .audio_en(audio_en)
   );

endmodule

// File: rtl/clk_ratio_seq_chk.sv
module clk_ratio_seq_chk #(
   parameter int ABSENT_CYC  = 40000,
   parameter int SYNC_STAGES = 2
) (
   input logic       clk_ref,
   input logic       rst_n,
   input logic       mst_clk_in,
   input logic       frame_clk_in,
   input logic [3:0] ratio_code,
   input logic [1:0] speed_mode,
   input logic       ref_en,
   input logic       conv_en,
   input logic       force_zero,
   input logic       audio_en
);
   localparam int            GW      = $clog2(ABSENT_CYC + 16);
   localparam logic [GW-1:0] GAP_LIM = GW'(ABSENT_CYC + 3);
   localparam logic [GW-1:0] GAP_MAX = '1;

   logic [SYNC_STAGES:0] m_sh, f_sh;
   logic [GW-1:0]        m_gap, f_gap;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         m_sh  <= '0;
         f_sh  <= '0;
         m_gap <= '0;
         f_gap <= '0;
      end else begin
         m_sh <= {m_sh[SYNC_STAGES-1:0], mst_clk_in};
         f_sh <= {f_sh[SYNC_STAGES-1:0], frame_clk_in};
         if (m_sh[SYNC_STAGES] ^ m_sh[SYNC_STAGES-1]) m_gap <= '0;
         else if (m_gap != GAP_MAX)                   m_gap <= m_gap + 1'b1;
         if (f_sh[SYNC_STAGES] ^ f_sh[SYNC_STAGES-1]) f_gap <= '0;
         else if (f_gap != GAP_MAX)                   f_gap <= f_gap + 1'b1;
      end
   end

   assert_absent_off_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (m_gap > GAP_LIM || f_gap > GAP_LIM) |-> (!ref_en && !audio_en && ratio_code == 4'hF));

   assert_code_range_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (ratio_code <= 4'd9) || (ratio_code == 4'hF));

   assert_audio_code_valid_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      audio_en |-> (ratio_code != 4'hF && speed_mode != 2'd3));

   assert_fixed_quad_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (ratio_code <= 4'd1) |-> (speed_mode == 2'd2));

   assert_fixed_single_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (ratio_code >= 4'd6 && ratio_code <= 4'd9) |-> (speed_mode == 2'd0));

   assert_conv_needs_ref_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      conv_en |-> ref_en);

   assert_ref_before_conv_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(conv_en) |-> $past(ref_en));

   assert_audio_after_conv_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(audio_en) |-> $past(conv_en));

   assert_release_with_conv_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(force_zero) |-> conv_en);

   assert_code_stable_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (audio_en && $past(audio_en)) |-> ($stable(ratio_code) && $stable(speed_mode)));

endmodule

bind clk_ratio_seq clk_ratio_seq_chk #(
   .ABSENT_CYC(ABSENT_CYC),
   .SYNC_STAGES(SYNC_STAGES)
) chk_i (
   .clk_ref(clk_ref),
   .rst_n(rst_n),
   .mst_clk_in(mst_clk_in),
   .frame_clk_in(frame_clk_in),
   .ratio_code(ratio_code),
   .speed_mode(speed_mode),
   .ref_en(ref_en),
   .conv_en(conv_en),
   .force_zero(force_zero),
   .audio_en(audio_en)
);

// File: tb/clk_ratio_seq_tb_top.sv
module clk_ratio_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int REF_HZ     = 80_400_000;
   localparam int ABSENT     = 8000;
   localparam int REF_FR     = 2;
   localparam int SETTLE_FR  = 5;
   localparam int QD_LIM     = REF_HZ / 134_000;
   localparam int DS_LIM     = REF_HZ / 67_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclk_drv = 1'b0;
   logic       frm_drv = 1'b0;
   logic [3:0] ratio_code;
   logic [1:0] speed_mode;
   logic       ref_en, conv_en, force_zero, audio_en;

   int gen_ratio = 64;
   int gen_h     = 1;
   bit gen_run   = 1'b0;
   int frame_no  = 0;
   int cur_ratio = 64;
   int cur_h     = 1;
   int checks    = 0;
   int errors    = 0;
   int prev_code = 15;
   int prev_spd  = 3;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_ratio_seq #(
      .REF_HZ(REF_HZ), .ABSENT_CYC(ABSENT),
      .REF_FRAMES(REF_FR), .SETTLE_FRAMES(SETTLE_FR)
   ) dut_i (
      .clk_ref(clk), .rst_n(rst_n), .mst_clk_in(mclk_drv), .frame_clk_in(frm_drv),
      .ratio_code(ratio_code), .speed_mode(speed_mode),
      .ref_en(ref_en), .conv_en(conv_en), .force_zero(force_zero), .audio_en(audio_en)
   );

   // clock pattern generator: one frame per loop pass
   initial begin
      forever begin
         if (!gen_run) @(negedge clk);
         else begin
            cur_ratio = gen_ratio;
            cur_h     = gen_h;
            frame_no++;
            for (int p = 0; p < cur_ratio; p++) begin
               frm_drv  = (p < cur_ratio / 2);
               mclk_drv = 1'b1;
               repeat (cur_h) @(negedge clk);
               mclk_drv = 1'b0;
               repeat (cur_h) @(negedge clk);
            end
         end
      end
   end

   function automatic int ratio_tab(input int i);
      case (i)
         0: return 64;    1: return 96;   2: return 128;  3: return 192;
         4: return 256;   5: return 384;  6: return 512;  7: return 768;
         8: return 1024;  default: return 1152;
      endcase
   endfunction

   function automatic int exp_code(input int ratio);
      for (int i = 0; i < 10; i++) begin
         if (ratio >= ratio_tab(i) - 2 && ratio <= ratio_tab(i) + 2) return i;
      end
      return 15;
   endfunction

   function automatic int exp_speed(input int ratio, input int h);
      int c, p;
      c = exp_code(ratio);
      p = ratio * 2 * h;
      case (c)
         0, 1:       return 2;
         2, 3:       return (p < QD_LIM) ? 2 : 1;
         4, 5:       return (p < DS_LIM) ? 1 : 0;
         6, 7, 8, 9: return 0;
         default:    return 3;
      endcase
   endfunction

   task automatic expect_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_state(input string req, input int r, input int c, input int a,
                               input int code, input int spd);
      expect_eq(req, "ref_en", int'(ref_en), r);
      expect_eq(req, "conv_en", int'(conv_en), c);
      expect_eq(req, "audio_en", int'(audio_en), a);
      expect_eq(req, "force_zero", int'(force_zero), (a != 0) ? 0 : 1);
      expect_eq(req, "ratio_code", int'(ratio_code), code);
      expect_eq(req, "speed_mode", int'(speed_mode), spd);
   endtask

   task automatic at_mid(input int n);
      wait (frame_no >= n);
      repeat ((cur_ratio * cur_h) / 2) @(negedge clk);
   endtask

   // accepted at frame base: check R8 and R9 staging plus the decode
   task automatic seq_check(input int base, input int ratio, input int h, input string req);
      int c, s;
      c = exp_code(ratio);
      s = exp_speed(ratio, h);
      at_mid(base);
      expect_eq(req, "code", int'(ratio_code), c);
      expect_eq(req, "speed", int'(speed_mode), s);
      expect_state("R8", 1, 0, 0, c, s);
      at_mid(base + REF_FR - 1);
      expect_state("R8", 1, 0, 0, c, s);
      at_mid(base + REF_FR);
      expect_state("R8", 1, 1, 0, c, s);
      at_mid(base + SETTLE_FR - 1);
      expect_state("R9", 1, 1, 0, c, s);
      at_mid(base + SETTLE_FR);
      expect_state("R9", 1, 1, 1, c, s);
      prev_code = c;
      prev_spd  = s;
   endtask

   task automatic switch_to(input int ratio, input int h, input string req);
      int f;
      f = frame_no + 1;
      gen_ratio = ratio;
      gen_h     = h;
      at_mid(f + 1);
      expect_state("R10", 0, 0, 0, 15, 3);
      seq_check(f + 2, ratio, h, req);
   endtask

   task automatic finish_up;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired before the run ended");
      finish_up();
   end

   initial begin
      int f, idx, h, r, c, s;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      expect_state("R1", 0, 0, 0, 15, 3);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      expect_state("R1", 0, 0, 0, 15, 3);

      // start up: first frame only arms the measurement (R8)
      gen_ratio = 256; gen_h = 1; gen_run = 1'b1;
      at_mid(1);
      expect_state("R8", 0, 0, 0, 15, 3);
      seq_check(2, 256, 1, "R7");

      // directed speed-class corners
      switch_to(128, 1, "R6");
      switch_to(128, 3, "R6");
      switch_to(384, 2, "R7");
      switch_to(1152, 1, "R5");
      switch_to(64, 1, "R5");
      switch_to(192, 2, "R6");

      // random legal patterns, each distinct from the last
      for (int k = 0; k < 3; k++) begin
         idx = int'($urandom % 10);
         h   = 1 + int'($urandom % 3);
         r   = ratio_tab(idx);
         if (r >= 512) h = 1;
         c = exp_code(r);
         s = exp_speed(r, h);
         if (c == prev_code && s == prev_spd) begin
            idx = (idx + 1) % 10;
            r   = ratio_tab(idx);
            if (r >= 512) h = 1;
         end
         switch_to(r, h, "R3");
      end

      // illegal count keeps the block muted in detection (R4)
      f = frame_no + 1;
      gen_ratio = 300; gen_h = 1;
      at_mid(f + 1);
      expect_state("R10", 0, 0, 0, 15, 3);
      at_mid(f + 2);
      expect_state("R4", 0, 0, 0, 15, 3);
      at_mid(f + 3);
      expect_state("R4", 0, 0, 0, 15, 3);

      // count inside the tolerance window maps to 256 (R4)
      f = frame_no + 1;
      gen_ratio = 258; gen_h = 1;
      seq_check(f + 1, 258, 1, "R4");

      // stop both clocks: timeout returns to power-down (R2)
      gen_run = 1'b0;
      repeat (ABSENT + 3000) @(negedge clk);
      expect_state("R2", 0, 0, 0, 15, 3);

      // restart from power-down with a new ratio (R3)
      f = frame_no + 1;
      gen_ratio = 1024; gen_h = 1; gen_run = 1'b1;
      at_mid(f);
      expect_state("R1", 0, 0, 0, 15, 3);
      seq_check(f + 1, 1024, 1, "R3");

      finish_up();
   end

endmodule